// File: doc/BRIEF.md
# Ethernet Test Frame Generator

This block produces Ethernet test frames on a streaming output. Each frame is a header made of a destination and a source MAC address, followed by a fill payload. The FCS is not part of the frame; the MAC downstream appends it. Each output word carries a start flag, an end flag and a byte count of unused lanes for the last word. A valid/ready handshake paces the stream.

A small register port configures the generator and starts or stops it. One control word selects the length mode and the gap policy. In random mode the length is drawn per frame. In fixed mode every frame has the programmed length. In incremental mode the length sweeps a programmed range. Between frames the generator either sends back to back or waits a random number of idle cycles. A packet count can be enabled so that fixed and incremental runs end by themselves.

The generator comes out of reset stopped. Software writes the size, count and address registers and then clears the stop bit. Setting the stop bit again ends the run at the next frame boundary.

Top module: `eth_testgen`

## Requirements
- R1: After reset the registers read: control 0x00000006 (stopped), size 0x25800040, count 0x0000000A, destination low/high 0x56780ADD/0x00001234, source low/high 0x43210ADD/0x00008765, identification 0x434C4E54 ("CLNT"). No frame is sent while stopped.
- R2: The scratch register reads back what was written. A write to the identification register has no effect on its read value.
- R3: Control bit 1 set to 0 runs the generator and set to 1 stops it. A stop written during a frame lets that frame finish, and no further frame starts.
- R4: With control bits [5:4] = 01 (fixed), every frame is exactly size[13:0] bytes long.
- R5: With control bits [5:4] = 10 (incremental), the first frame after a start is size[13:0] bytes. Each later frame is one byte longer. After a frame of size[29:16] bytes the length returns to size[13:0].
- R6: With control bits [5:4] = 00 (random), every frame length lies between 64 and size[29:16] inclusive.
- R7: Count register bit 31 enables a count held in bits [30:0]. In fixed or incremental mode each started frame decrements the count. Control bit 1 sets itself once the count reaches zero, so exactly the programmed number of frames is sent. An enabled count of zero starts no frame and sets the stop bit. In random mode the count is neither used nor changed.
- R8: With control bit 6 = 1, the start of the next frame appears in the cycle right after the last word of the previous frame is accepted.
- R9: With control bit 6 = 0, the idle gap between frames is 0 to 15 cycles and varies from frame to frame.
- R10: Frame byte n is placed at tx_data[8*(BYTES-n%BYTES)-1 -: 8] of word n/BYTES. Bytes 0-5 are the destination MAC, most significant byte first. Bytes 6-11 are the source MAC in the same order. Byte n for n >= 12 equals n mod 256.
- R11: While tx_valid is high and tx_ready is low, tx_data, tx_sop, tx_eop and tx_empty hold their values. tx_sop marks the first word and tx_eop the last. On the last word, tx_empty gives the number of unused bytes.
- R12: The word address map is: 0 identification, 1 scratch, 2 control (bits [6:0] read back), 3 size, 4 count (reads the remaining count), 5/6 destination low/high, 7/8 source low/high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_ready | input | 1 | Sink accepts the current word |
| tx_valid | output | 1 | Word on tx_data is valid |
| tx_sop | output | 1 | First word of a frame |
| tx_eop | output | 1 | Last word of a frame |
| tx_empty | output | $clog2(BYTES) | Unused bytes in the last word |
| tx_data | output | 8*BYTES | Frame data, first byte in the top lane |

## Verification
The bench builds the generator with the default 8-byte word and the default random seed. Frames of 64 to 200 bytes therefore span 8 to 25 words. The chosen lengths (64-67, 70, 100, 200) give last-word empty counts of 0, 2, 4, 5, 6 and 7, and they also reach the incremental wrap at a short upper limit. Since the random seed is fixed, each random-mode run is repeatable. The random upper limit is set low enough that the clamp at both ends of the range comes into play.

// File: rtl/eth_testgen_pkg.sv
`timescale 1ns/1ps
package eth_testgen_pkg;

    localparam int LEN_W  = 14;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        MODE_RAND  = 2'b00,
        MODE_FIXED = 2'b01,
        MODE_INCR  = 2'b10,
        MODE_RSVD  = 2'b11
    } len_mode_e;

    localparam logic [ADDR_W-1:0] A_IDENT   = 4'd0;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd2;
    localparam logic [ADDR_W-1:0] A_SIZE    = 4'd3;
    localparam logic [ADDR_W-1:0] A_COUNT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_DST_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_DST_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] A_SRC_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] A_SRC_HI  = 4'd8;

    localparam logic [31:0] IDENT_WORD = 32'h434C_4E54;

    typedef struct packed {
        logic [31:0]      scratch;
        logic [6:0]       ctrl;
        logic [LEN_W-1:0] upper;
        logic [LEN_W-1:0] lower;
        logic             cnt_en;
        logic [30:0]      cnt;
        logic [47:0]      dst;
        logic [47:0]      src;
    } regs_t;

endpackage

// File: rtl/eth_testgen_lfsr.sv
`timescale 1ns/1ps
module eth_testgen_lfsr #(
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] rnd
);
    localparam logic [31:0] TAPS = 32'h8020_0003;

    logic [31:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? TAPS : 32'h0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd = lfsr_q;

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 32'h0);  // R9
endmodule

// File: rtl/eth_testgen_regs.sv
`timescale 1ns/1ps
module eth_testgen_regs
    import eth_testgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_start,
    input  logic              frame_halt,
    output logic              run,
    output logic              b2b,
    output len_mode_e         mode,
    output logic [LEN_W-1:0]  upper,
    output logic [LEN_W-1:0]  lower,
    output logic              counted,
    output logic              cnt_zero,
    output logic [47:0]       dst,
    output logic [47:0]       src
);
    localparam regs_t RESET_REGS = '{
        scratch: 32'h0,
        ctrl:    7'h06,
        upper:   LEN_W'(9600),
        lower:   LEN_W'(64),
        cnt_en:  1'b0,
        cnt:     31'd10,
        dst:     48'h1234_5678_0ADD,
        src:     48'h8765_4321_0ADD
    };

    regs_t r_d, r_q;

    assign run      = ~r_q.ctrl[1];
    assign b2b      = r_q.ctrl[6];
    assign mode     = len_mode_e'(r_q.ctrl[5:4]);
    assign upper    = r_q.upper;
    assign lower    = r_q.lower;
    assign counted  = r_q.cnt_en && (mode == MODE_FIXED || mode == MODE_INCR);
    assign cnt_zero = (r_q.cnt == 31'd0);
    assign dst      = r_q.dst;
    assign src      = r_q.src;

    always_comb begin
        r_d = r_q;
        if (frame_halt) r_d.ctrl[1] = 1'b1;
        if (frame_start && counted) begin
            r_d.cnt = r_q.cnt - 31'd1;
            if (r_q.cnt == 31'd1) r_d.ctrl[1] = 1'b1;
        end
        if (reg_wr) begin
            case (reg_addr)
                A_SCRATCH: r_d.scratch = reg_wdata;
                A_CTRL:    r_d.ctrl    = reg_wdata[6:0];
                A_SIZE: begin
                    r_d.upper = reg_wdata[16+LEN_W-1:16];
                    r_d.lower = reg_wdata[LEN_W-1:0];
                end
                A_COUNT: begin
                    r_d.cnt_en = reg_wdata[31];
                    r_d.cnt    = reg_wdata[30:0];
                end
                A_DST_LO:  r_d.dst[31:0]  = reg_wdata;
                A_DST_HI:  r_d.dst[47:32] = reg_wdata[15:0];
                A_SRC_LO:  r_d.src[31:0]  = reg_wdata;
                A_SRC_HI:  r_d.src[47:32] = reg_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            A_IDENT:   reg_rdata = IDENT_WORD;
            A_SCRATCH: reg_rdata = r_q.scratch;
            A_CTRL:    reg_rdata = {25'h0, r_q.ctrl};
            A_SIZE:    reg_rdata = {2'b00, r_q.upper, 2'b00, r_q.lower};
            A_COUNT:   reg_rdata = {r_q.cnt_en, r_q.cnt};
            A_DST_LO:  reg_rdata = r_q.dst[31:0];
            A_DST_HI:  reg_rdata = {16'h0, r_q.dst[47:32]};
            A_SRC_LO:  reg_rdata = r_q.src[31:0];
            A_SRC_HI:  reg_rdata = {16'h0, r_q.src[47:32]};
            default:   reg_rdata = 32'h0;
        endcase
    end

    AST_COUNT_SELF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && counted && r_q.cnt == 31'd1 && !reg_wr) |=> !run);  // R7
endmodule

// File: rtl/eth_testgen_core.sv
`timescale 1ns/1ps
module eth_testgen_core
    import eth_testgen_pkg::*;
#(
    parameter int BYTES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       b2b,
    input  len_mode_e                  mode,
    input  logic [LEN_W-1:0]           upper,
    input  logic [LEN_W-1:0]           lower,
    input  logic                       counted,
    input  logic                       cnt_zero,
    input  logic [47:0]                dst,
    input  logic [47:0]                src,
    input  logic [31:0]                rnd,
    output logic                       frame_start,
    output logic                       frame_halt,
    input  logic                       tx_ready,
    output logic                       tx_valid,
    output logic                       tx_sop,
    output logic                       tx_eop,
    output logic [$clog2(BYTES)-1:0]   tx_empty,
    output logic [8*BYTES-1:0]         tx_data
);
    localparam int LOG_B  = $clog2(BYTES);
    localparam int WORD_W = LEN_W - LOG_B;
    localparam int DATA_W = 8 * BYTES;
    localparam logic [LEN_W-1:0] RAND_MIN = LEN_W'(64);

    typedef enum logic {ST_IDLE, ST_SEND} st_e;

    typedef struct packed {
        st_e               st;
        logic [3:0]        gap;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] last;
        logic [LOG_B-1:0]  empty;
        logic [LEN_W-1:0]  inc;
        logic [47:0]       dst;
        logic [47:0]       src;
    } core_t;

    core_t q, n;

    logic             beat_acc, last_acc, want;
    logic [3:0]       gap_pick;
    logic [LEN_W-1:0] rlen, rlen_cl, len, len_m1;

    function automatic logic [7:0] byte_at(input logic [LEN_W-1:0] off,
                                           input logic [47:0] d,
                                           input logic [47:0] s);
        int i;
        i = int'(off);
        if (i < 6)       return d[47-8*i -: 8];
        else if (i < 12) return s[47-8*(i-6) -: 8];
        else             return off[7:0];
    endfunction

    always_comb begin
        n        = q;
        beat_acc = (q.st == ST_SEND) && tx_ready;
        last_acc = beat_acc && (q.word == q.last);
        gap_pick = b2b ? 4'd0 : rnd[3:0];
        want     = ((q.st == ST_IDLE) && (q.gap == 4'd0)) ||
                   (last_acc && (gap_pick == 4'd0));

        frame_halt  = want && run && counted && cnt_zero;
        frame_start = want && run && !(counted && cnt_zero);

        rlen = rnd[LEN_W+3:4];
        if (rlen < RAND_MIN)   rlen_cl = RAND_MIN;
        else if (rlen > upper) rlen_cl = upper;
        else                   rlen_cl = rlen;

        case (mode)
            MODE_FIXED: len = lower;
            MODE_INCR:  len = q.inc;
            default:    len = rlen_cl;
        endcase
        len_m1 = len - LEN_W'(1);

        if (!run && q.st == ST_IDLE) n.inc = lower;

        if (beat_acc && !last_acc) n.word = q.word + WORD_W'(1);

        if (last_acc) begin
            n.st  = ST_IDLE;
            n.gap = (gap_pick == 4'd0) ? 4'd0 : gap_pick - 4'd1;
        end else if (q.st == ST_IDLE && q.gap != 4'd0) begin
            n.gap = q.gap - 4'd1;
        end

        if (frame_start) begin
            n.st    = ST_SEND;
            n.gap   = 4'd0;
            n.word  = '0;
            n.last  = len_m1[LEN_W-1:LOG_B];
            n.empty = (~len[LOG_B-1:0]) + LOG_B'(1);
            n.dst   = dst;
            n.src   = src;
            if (mode == MODE_INCR)
                n.inc = (q.inc >= upper) ? lower : q.inc + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.inc   <= LEN_W'(64);
        end else begin
            q <= n;
        end
    end

    assign tx_valid = (q.st == ST_SEND);
    assign tx_sop   = tx_valid && (q.word == '0);
    assign tx_eop   = tx_valid && (q.word == q.last);
    assign tx_empty = tx_eop ? q.empty : '0;

    always_comb begin
        tx_data = '0;
        for (int k = 0; k < BYTES; k++)
            tx_data[DATA_W-1-8*k -: 8] = byte_at({q.word, LOG_B'(k)}, q.dst, q.src);
    end

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) &&
                                     $stable(tx_eop) && $stable(tx_empty)));  // R11
    AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !(tx_ready && tx_eop)) |=> tx_valid);  // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !run) |=> !tx_valid);  // R3
    AST_B2B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_eop && b2b && run && !counted) |=> (tx_valid && tx_sop));  // R8
endmodule

// File: rtl/eth_testgen.sv
`timescale 1ns/1ps
module eth_testgen
    import eth_testgen_pkg::*;
#(
    parameter int          BYTES = 8,
    parameter logic [31:0] SEED  = 32'hACE1_2468
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [3:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic                     tx_ready,
    output logic                     tx_valid,
    output logic                     tx_sop,
    output logic                     tx_eop,
    output logic [$clog2(BYTES)-1:0] tx_empty,
    output logic [8*BYTES-1:0]       tx_data
);
    logic             run, b2b, counted, cnt_zero, frame_start, frame_halt;
    len_mode_e        mode;
    logic [LEN_W-1:0] upper, lower;
    logic [47:0]      dst, src;
    logic [31:0]      rnd;

    eth_testgen_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_start(frame_start), .frame_halt(frame_halt),
        .run(run), .b2b(b2b), .mode(mode), .upper(upper), .lower(lower),
        .counted(counted), .cnt_zero(cnt_zero), .dst(dst), .src(src)
    );

    eth_testgen_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    eth_testgen_core #(.BYTES(BYTES)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run(run), .b2b(b2b), .mode(mode), .upper(upper), .lower(lower),
        .counted(counted), .cnt_zero(cnt_zero), .dst(dst), .src(src), .rnd(rnd),
        .frame_start(frame_start), .frame_halt(frame_halt),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_empty(tx_empty), .tx_data(tx_data)
    );
endmodule

// File: tb/eth_testgen_tb.sv
`timescale 1ns/1ps
module eth_testgen_tb;
    localparam int BYTES = 8;
    localparam int LB    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        tx_ready = 1'b1;
    logic        tx_valid, tx_sop, tx_eop;
    logic [LB-1:0] tx_empty;
    logic [8*BYTES-1:0] tx_data;

    eth_testgen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_empty(tx_empty), .tx_data(tx_data)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, bp_en = 0;
    logic [47:0] exp_dst = 48'h1234_5678_0ADD;
    logic [47:0] exp_src = 48'h8765_4321_0ADD;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor state
    int nf = 0, hold_err = 0, stall_cnt = 0, wcnt = 0, last_eop_cyc = 0;
    int flen[64];
    int fgap[64];
    bit fbad[64];
    bit in_frame = 0, cur_bad = 0, stall_p = 0, p_sop, p_eop;
    logic [LB-1:0] p_empty;
    logic [8*BYTES-1:0] p_data;

    function automatic logic [7:0] exp_byte(int off);
        if (off < 6)       return exp_dst[47-8*off -: 8];
        else if (off < 12) return exp_src[47-8*(off-6) -: 8];
        else               return off[7:0];
    endfunction

    always @(negedge clk) if (rst_n) begin
        if (stall_p && (!tx_valid || tx_data !== p_data || tx_sop !== p_sop ||
                        tx_eop !== p_eop || tx_empty !== p_empty)) hold_err++;
        if (tx_valid && !in_frame) begin
            in_frame = 1; wcnt = 0; cur_bad = 0;
            if (nf < 64) fgap[nf] = cyc - last_eop_cyc - 1;
        end
        if (tx_valid && tx_ready) begin
            if (tx_sop !== (wcnt == 0)) cur_bad = 1;
            for (int k = 0; k < BYTES; k++)
                if (!tx_eop || k < BYTES - int'(tx_empty))
                    if (tx_data[8*BYTES-1-8*k -: 8] !== exp_byte(wcnt*BYTES + k)) cur_bad = 1;
            if (!tx_eop && tx_empty !== '0) cur_bad = 1;
            wcnt++;
            if (tx_eop) begin
                if (nf < 64) begin
                    flen[nf] = wcnt*BYTES - int'(tx_empty);
                    fbad[nf] = cur_bad;
                end
                nf++; in_frame = 0; last_eop_cyc = cyc;
            end
        end
        stall_p = tx_valid && !tx_ready;
        if (stall_p) stall_cnt++;
        p_data = tx_data; p_sop = tx_sop; p_eop = tx_eop; p_empty = tx_empty;
    end

    initial begin : ready_drive
        logic [15:0] bp;
        bp = 16'hBEEF;
        forever begin
            @(posedge clk); #1;
            bp = {bp[14:0], bp[15] ^ bp[13] ^ bp[12] ^ bp[10]};
            tx_ready = bp_en ? bp[0] : 1'b1;
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 40) begin
            @(negedge clk);
            if (tx_valid) q = 0; else q++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int idle = 0;
        reg_read(4'd2, v); chk("R1", "ctrl reset", v, 32'h6);
        reg_read(4'd3, v); chk("R1", "size reset", v, 32'h2580_0040);
        reg_read(4'd4, v); chk("R1", "count reset", v, 32'hA);
        reg_read(4'd5, v); chk("R1", "dst lo reset", v, 32'h5678_0ADD);
        reg_read(4'd6, v); chk("R1", "dst hi reset", v, 32'h1234);
        reg_read(4'd7, v); chk("R1", "src lo reset", v, 32'h4321_0ADD);
        reg_read(4'd8, v); chk("R1", "src hi reset", v, 32'h8765);
        reg_read(4'd0, v); chk("R12", "ident", v, 32'h434C_4E54);
        repeat (30) begin @(negedge clk); if (!tx_valid) idle++; end
        chk("R1", "idle while stopped", idle, 30);
    endtask

    task automatic t_scratch();
        logic [31:0] v;
        reg_write(4'd1, 32'hDEAD_BEEF);
        reg_read(4'd1, v); chk("R2", "scratch readback", v, 32'hDEAD_BEEF);
        reg_write(4'd0, 32'h0);
        reg_read(4'd0, v); chk("R2", "ident after write", v, 32'h434C_4E54);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        int base = nf;
        reg_write(4'd3, {2'b0, 14'd9600, 2'b0, 14'd70});
        reg_write(4'd4, 32'h8000_0003);
        reg_write(4'd2, 32'h50);
        wait_quiet();
        chk("R7", "fixed frame count", nf - base, 3);
        for (int i = base; i < base + 3 && i < 64; i++) begin
            chk("R4", "fixed length", flen[i], 70);
            chk("R10", "fixed content", fbad[i], 0);
        end
        chk("R8", "b2b gap 2", fgap[base+1], 0);
        chk("R8", "b2b gap 3", fgap[base+2], 0);
        reg_read(4'd4, v); chk("R7", "count drained", v, 32'h8000_0000);
        reg_read(4'd2, v); chk("R12", "ctrl after self stop", v, 32'h52);
    endtask

    task automatic t_incr();
        int exp_l[6] = '{64, 65, 66, 67, 64, 65};
        int base = nf;
        exp_dst = 48'hA1B2_C3D4_E5F6;
        exp_src = 48'h0102_0304_0506;
        reg_write(4'd5, 32'hC3D4_E5F6);
        reg_write(4'd6, 32'h0000_A1B2);
        reg_write(4'd7, 32'h0304_0506);
        reg_write(4'd8, 32'h0000_0102);
        reg_write(4'd3, {2'b0, 14'd67, 2'b0, 14'd64});
        reg_write(4'd4, 32'h8000_0006);
        bp_en = 1;
        reg_write(4'd2, 32'h60);
        wait_quiet();
        bp_en = 0;
        chk("R5", "incr frame count", nf - base, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R5", "incr length", flen[base+i], exp_l[i]);
            chk("R10", "incr content new MACs", fbad[base+i], 0);
        end
        chk("R11", "stalls seen", stall_cnt > 0, 1);
        chk("R11", "held under stall", hold_err, 0);
    endtask

    task automatic t_random();
        logic [31:0] v;
        int base = nf, gmax = 0, gsum = 0, bad = 0, lbad = 0;
        reg_write(4'd3, {2'b0, 14'd100, 2'b0, 14'd64});
        reg_write(4'd4, 32'h8000_0002);
        reg_write(4'd2, 32'h00);
        while (nf - base < 12) @(negedge clk);
        reg_write(4'd2, 32'h02);
        wait_quiet();
        chk("R7", "random ignores count", nf - base >= 12, 1);
        for (int i = base; i < nf && i < 64; i++) begin
            if (flen[i] < 64 || flen[i] > 100) lbad++;
            if (fbad[i]) bad++;
            if (i > base) begin
                gsum += fgap[i];
                if (fgap[i] > gmax) gmax = fgap[i];
            end
        end
        chk("R6", "random lengths in range", lbad, 0);
        chk("R10", "random content", bad, 0);
        chk("R9", "gap max <= 15", gmax <= 15, 1);
        chk("R9", "some gap nonzero", gsum > 0, 1);
        reg_read(4'd4, v); chk("R7", "count untouched in random", v, 32'h8000_0002);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int base = nf;
        reg_write(4'd3, {2'b0, 14'd9600, 2'b0, 14'd200});
        reg_write(4'd4, 32'h0000_0000);
        reg_write(4'd2, 32'h50);
        while (!tx_valid) @(negedge clk);
        repeat (3) @(posedge clk);
        reg_write(4'd2, 32'h52);
        wait_quiet();
        chk("R3", "one frame after mid stop", nf - base, 1);
        chk("R3", "frame completed", flen[base], 200);
        chk("R10", "long frame content", fbad[base], 0);
        reg_read(4'd2, v); chk("R3", "stop bit", v[1], 1);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        int base = nf;
        reg_write(4'd4, 32'h8000_0000);
        reg_write(4'd2, 32'h50);
        repeat (30) @(negedge clk);
        chk("R7", "zero count sends none", nf - base, 0);
        reg_read(4'd2, v); chk("R7", "zero count stops", v[1], 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_scratch();
        t_fixed();
        t_incr();
        t_random();
        t_stop();
        t_zero_count();
        finish_run();
    end
endmodule